// File: doc/BRIEF.md
# Flash Command Engine Status Register

This block holds the 16-bit status word of a non-volatile memory command engine. The engine reports what happens through single-cycle event strobes: an operation starting or finishing, a suspend or resume, and a set of failure causes. The host reads the word and acknowledges failures by writing ones to the bits it wants to clear.

Three bits describe the engine's state and belong to hardware alone: ready (bit 7), erase suspended (bit 6) and program suspended (bit 2). Six bits are error flags that the host may clear: locked-block write (bit 1), bad programming voltage (bit 3), program failure (bit 4), erase failure (bit 5), and a two-bit region error code in {bit 9, bit 8}. While the engine is busy, the error flags have no meaning. The read port then shows only the busy and suspend state, but the stored flags are kept.

The host read path is combinational from the stored word. Every event and host write takes effect at the next rising clock edge.

Top module: `flashStatusReg`

## Requirements
- R1: After reset the word reads 0x0080: ready set and every other bit zero.
- R2: Bits 15:10 and bit 0 always read zero, and host writes to them have no effect.
- R3: A host write clears each of bits 1, 3, 4, 5, 8 and 9 where the written data holds a 1, and leaves it unchanged where the data holds a 0.
- R4: Host writes never change bits 7, 6 or 2.
- R5: The strobes evLockErr, evVoltErr, evProgErr and evEraseErr set bit 1, bit 3, bit 4 and bit 5 respectively. The flag is visible on the next cycle and stays set until the host clears it.
- R6: The evSeqErr strobe sets bits 4 and 5 together, so a ready word with no other flags reads 0x00B0.
- R7: The evRegionErr strobe ORs evRegionCode into {bit 9, bit 8}. The codes are 01 for an object-mode region, 10 for an invalid region element and 11 for an illegal command. A nonzero code also sets bit 4, and code 00 changes nothing.
- R8: evStart clears bit 7 and evDone sets it. If both arrive in the same cycle, evDone wins.
- R9: evSuspend sets bit 7 together with bit 6 (evSuspErase=1) or bit 2 (evSuspErase=0). evResume clears both suspend bits and bit 7. A suspend arriving in the same cycle as a resume wins for the bit it sets and for bit 7.
- R10: While bit 7 is 0, a read returns only bits 6 and 2, and every error bit reads 0. The stored flags reappear once the word is ready again.
- R11: If an engine set and a host clear hit the same error bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write data; a 1 clears the matching error bit |
| hostRdData | output | 16 | Status word as the host sees it |
| evStart | input | 1 | Engine begins an operation |
| evDone | input | 1 | Engine finishes an operation |
| evSuspend | input | 1 | Engine has halted on a suspend request |
| evSuspErase | input | 1 | Suspend kind: 1 erase, 0 program |
| evResume | input | 1 | Engine resumes a suspended operation |
| evLockErr | input | 1 | Write attempted on a locked block |
| evVoltErr | input | 1 | Programming voltage out of range |
| evProgErr | input | 1 | Program failure |
| evEraseErr | input | 1 | Erase failure |
| evSeqErr | input | 1 | Command sequence error |
| evRegionErr | input | 1 | Region error, code on evRegionCode |
| evRegionCode | input | 2 | Region error code |

## Verification
The assertions check several rules on every cycle: reserved bits stay zero, busy reads hide the error flags, a set strobe always leaves its flag standing, a host clear takes effect, and ready and the suspend bits move only on engine events. Other behaviour needs ordered scenarios in the bench. This covers the full sweep of clear masks against a fully flagged word, the region code encodings, flags reappearing after a busy period, and the priority between simultaneous suspend and resume or start and done.

// File: rtl/flashStsPkg.sv
package flashStsPkg;
  localparam int StsWidth = 16;
  localparam int ReadyBit = 7;
  localparam int EraseSuspBit = 6;
  localparam int ProgSuspBit = 2;
  localparam int LockBit = 1;
  localparam int VoltBit = 3;
  localparam int ProgBit = 4;
  localparam int EraseBit = 5;
  localparam int RegionLoBit = 8;
  localparam int RegionHiBit = 9;

  localparam logic [StsWidth-1:0] ClearableMask = 16'h033A;
  localparam logic [StsWidth-1:0] SuspMask = 16'h0044;
  localparam logic [StsWidth-1:0] ResetValue = 16'h0080;

  typedef struct packed {
    logic [StsWidth-1:0] errSet;
    logic [StsWidth-1:0] errClr;
    logic readySet;
    logic readyClr;
    logic eraseSuspSet;
    logic progSuspSet;
    logic suspClr;
  } stsCtlT;
endpackage

// File: rtl/flashStsCtl.sv
module flashStsCtl
  import flashStsPkg::*;
(
  input  logic                hostWrEn,
  input  logic [StsWidth-1:0] hostWrData,
  input  logic                evStart,
  input  logic                evDone,
  input  logic                evSuspend,
  input  logic                evSuspErase,
  input  logic                evResume,
  input  logic                evLockErr,
  input  logic                evVoltErr,
  input  logic                evProgErr,
  input  logic                evEraseErr,
  input  logic                evSeqErr,
  input  logic                evRegionErr,
  input  logic [1:0]          evRegionCode,
  output stsCtlT              ctl
);
  logic regionHit;

  always_comb begin
    regionHit = evRegionErr && (evRegionCode != 2'b00);
    ctl = '0;
    ctl.errSet[LockBit]     = evLockErr;
    ctl.errSet[VoltBit]     = evVoltErr;
    ctl.errSet[ProgBit]     = evProgErr | evSeqErr | regionHit;
    ctl.errSet[EraseBit]    = evEraseErr | evSeqErr;
    ctl.errSet[RegionLoBit] = evRegionErr & evRegionCode[0];
    ctl.errSet[RegionHiBit] = evRegionErr & evRegionCode[1];
    ctl.errClr       = hostWrEn ? (hostWrData & ClearableMask) : '0;
    ctl.readySet     = evDone | evSuspend;
    ctl.readyClr     = evStart | evResume;
    ctl.eraseSuspSet = evSuspend & evSuspErase;
    ctl.progSuspSet  = evSuspend & ~evSuspErase;
    ctl.suspClr      = evResume;
  end
endmodule

// File: rtl/flashStsData.sv
module flashStsData
  import flashStsPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stsCtlT              ctl,
  output logic [StsWidth-1:0] stsRaw,
  output logic [StsWidth-1:0] rdData
);
  logic [StsWidth-1:0] stsQ;
  logic [StsWidth-1:0] errNext;
  logic [StsWidth-1:0] stateNext;
  logic readyNext;
  logic eraseSuspNext;
  logic progSuspNext;

  always_comb begin
    // set beats clear: the set term is ORed after the clear is applied
    errNext = ((stsQ & ~ctl.errClr) | ctl.errSet) & ClearableMask;

    if (ctl.readySet)      readyNext = 1'b1;
    else if (ctl.readyClr) readyNext = 1'b0;
    else                   readyNext = stsQ[ReadyBit];

    if (ctl.eraseSuspSet)  eraseSuspNext = 1'b1;
    else if (ctl.suspClr)  eraseSuspNext = 1'b0;
    else                   eraseSuspNext = stsQ[EraseSuspBit];

    if (ctl.progSuspSet)   progSuspNext = 1'b1;
    else if (ctl.suspClr)  progSuspNext = 1'b0;
    else                   progSuspNext = stsQ[ProgSuspBit];

    stateNext = '0;
    stateNext[ReadyBit]     = readyNext;
    stateNext[EraseSuspBit] = eraseSuspNext;
    stateNext[ProgSuspBit]  = progSuspNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsQ <= ResetValue;
    else       stsQ <= errNext | stateNext;
  end

  assign stsRaw = stsQ;

  always_comb begin
    if (stsQ[ReadyBit]) rdData = stsQ & (ClearableMask | SuspMask | ResetValue);
    else                rdData = stsQ & SuspMask;
  end
endmodule

// File: rtl/flashStatusReg.sv
module flashStatusReg
  import flashStsPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [StsWidth-1:0] hostWrData,
  output logic [StsWidth-1:0] hostRdData,
  input  logic                evStart,
  input  logic                evDone,
  input  logic                evSuspend,
  input  logic                evSuspErase,
  input  logic                evResume,
  input  logic                evLockErr,
  input  logic                evVoltErr,
  input  logic                evProgErr,
  input  logic                evEraseErr,
  input  logic                evSeqErr,
  input  logic                evRegionErr,
  input  logic [1:0]          evRegionCode
);
  stsCtlT ctl;
  logic [StsWidth-1:0] stsRaw;

  flashStsCtl uCtl (
    .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .evStart(evStart), .evDone(evDone), .evSuspend(evSuspend),
    .evSuspErase(evSuspErase), .evResume(evResume),
    .evLockErr(evLockErr), .evVoltErr(evVoltErr), .evProgErr(evProgErr),
    .evEraseErr(evEraseErr), .evSeqErr(evSeqErr),
    .evRegionErr(evRegionErr), .evRegionCode(evRegionCode),
    .ctl(ctl)
  );

  flashStsData uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stsRaw(stsRaw), .rdData(hostRdData)
  );
endmodule

// File: rtl/flashStsChk.sv
module flashStsChk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] stsRaw,
  input logic [15:0] hostRdData,
  input logic        hostWrEn,
  input logic        hostClrLock,
  input logic        evStart,
  input logic        evDone,
  input logic        evSuspend,
  input logic        evResume,
  input logic        evLockErr,
  input logic        evProgErr,
  input logic        evSeqErr
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hostRdData & 16'hFC01) == 16'h0) && ((stsRaw & 16'hFC01) == 16'h0));

  // R10
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdData[7] |-> ((hostRdData & 16'h033A) == 16'h0));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evProgErr |=> stsRaw[4]);

  // R3
  host_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostClrLock && !evLockErr) |=> !stsRaw[1]);

  // R4
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!evStart && !evDone && !evSuspend && !evResume) |=> $stable(stsRaw[7]) && $stable(stsRaw[6]) && $stable(stsRaw[2]));

  // R9
  suspend_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    evSuspend |=> stsRaw[7] && (stsRaw[6] || stsRaw[2]));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evStart && !evDone && !evSuspend) |=> !stsRaw[7]);

  // R6
  seq_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    evSeqErr |=> stsRaw[4] && stsRaw[5]);
endmodule

bind flashStatusReg flashStsChk uChk (
  .clk(clk), .rstN(rstN), .stsRaw(stsRaw), .hostRdData(hostRdData),
  .hostWrEn(hostWrEn), .hostClrLock(hostWrData[1]),
  .evStart(evStart), .evDone(evDone), .evSuspend(evSuspend),
  .evResume(evResume), .evLockErr(evLockErr), .evProgErr(evProgErr),
  .evSeqErr(evSeqErr)
);

// File: tb/tb_flashStatusReg.sv
`timescale 1ns/1ps
module tb_flashStatusReg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic evStart = 0, evDone = 0, evSuspend = 0, evSuspErase = 0, evResume = 0;
  logic evLockErr = 0, evVoltErr = 0, evProgErr = 0, evEraseErr = 0;
  logic evSeqErr = 0, evRegionErr = 0;
  logic [1:0] evRegionCode = 2'b00;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flashStatusReg dut (.*);

  task automatic idle();
    hostWrEn = 0; hostWrData = '0;
    evStart = 0; evDone = 0; evSuspend = 0; evSuspErase = 0; evResume = 0;
    evLockErr = 0; evVoltErr = 0; evProgErr = 0; evEraseErr = 0;
    evSeqErr = 0; evRegionErr = 0; evRegionCode = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (hostRdData !== exp) begin
      fails++;
      $display("FAIL %s: read 0x%04h expected 0x%04h", req, hostRdData, exp);
    end
  endtask

  task automatic clearAll();
    hostWrEn = 1; hostWrData = 16'hFFFF; tick();
  endtask

  function automatic logic [15:0] maskFrom(input int m);
    logic [15:0] r = '0;
    r[1] = m[0]; r[3] = m[1]; r[4] = m[2];
    r[5] = m[3]; r[8] = m[4]; r[9] = m[5];
    return r;
  endfunction

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 check("R1", 16'h0080);
    rstN = 1;
    @(posedge clk); #1;
    check("R1", 16'h0080);

    // R2 R4: writing every bit leaves the reset word
    clearAll();
    check("R2/R4", 16'h0080);

    // R5 + R3: all combinations of the four single-cause strobes
    for (int e = 0; e < 16; e++) begin
      evLockErr = e[0]; evVoltErr = e[1]; evProgErr = e[2]; evEraseErr = e[3];
      tick();
      check("R5", 16'h0080 | (e[0] ? 16'h0002 : 16'h0) | (e[1] ? 16'h0008 : 16'h0)
                           | (e[2] ? 16'h0010 : 16'h0) | (e[3] ? 16'h0020 : 16'h0));
      clearAll();
      check("R3", 16'h0080);
    end

    // R6
    evSeqErr = 1; tick();
    check("R6", 16'h00B0);
    clearAll();

    // R7 region codes
    for (int c = 0; c < 4; c++) begin
      evRegionErr = 1; evRegionCode = c[1:0]; tick();
      check("R7", 16'h0080 | (16'(c) << 8) | ((c != 0) ? 16'h0010 : 16'h0));
      clearAll();
    end

    // R3 sweep of every clear mask over a fully flagged word
    for (int m = 0; m < 64; m++) begin
      evLockErr = 1; evVoltErr = 1; evSeqErr = 1;
      evRegionErr = 1; evRegionCode = 2'b11; tick();
      hostWrEn = 1; hostWrData = maskFrom(m) | 16'hFC01; tick();
      check("R3", 16'h03BA & ~maskFrom(m));
      clearAll();
    end

    // R11 set beats a simultaneous clear
    evLockErr = 1; tick();
    evProgErr = 1; hostWrEn = 1; hostWrData = 16'h0012; tick();
    check("R11", 16'h0090);
    clearAll();

    // R8 / R10
    evLockErr = 1; tick();
    check("R5", 16'h0082);
    evStart = 1; tick();
    check("R10", 16'h0000);
    evProgErr = 1; tick();
    check("R10", 16'h0000);
    evDone = 1; tick();
    check("R10", 16'h0092);
    evStart = 1; evDone = 1; tick();
    check("R8", 16'h0092);
    clearAll();

    // R9 suspend and resume
    evStart = 1; tick();
    check("R8", 16'h0000);
    evSuspend = 1; evSuspErase = 1; tick();
    check("R9", 16'h00C0);
    hostWrEn = 1; hostWrData = 16'hFFFF; tick();
    check("R4", 16'h00C0);
    evResume = 1; tick();
    check("R9", 16'h0000);
    evSuspend = 1; evSuspErase = 0; tick();
    check("R9", 16'h0084);
    evSuspend = 1; evSuspErase = 0; evResume = 1; tick();
    check("R9", 16'h0084);
    evStart = 1; tick();
    check("R10", 16'h0004);
    evResume = 1; tick();
    check("R9", 16'h0000);
    evDone = 1; tick();
    check("R8", 16'h0080);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule